// File: doc/BRIEF.md
# Shift-Chain Upset Monitor

This block is a test structure for measuring how often storage elements lose their state under particle strikes. It is a long chain of flip-flop stages that moves an alternating 0/1 pattern from a built-in source to the last stage. A selectable group of inverters sits on every link between stages. A checker at the tail compares the last stage, every clock, with the value the pattern must have there. That expected value already includes the polarity that the inverter links add along the chain. Mismatches are counted, flagged and located.

Each stage holds three copies of its bit. In plain mode only the first copy is used. In hardened mode the stage output is the majority of the three copies, and the single link into the stage feeds all three. While the chain is paused, the voted value is written back into every copy, so that one corrupted copy is repaired on the next clock. A strike input flips one chosen copy of one chosen stage for a cycle, so that the response to an upset can be exercised without a beam.

Top module: `shift_upset_monitor`

## Requirements
- R1: After reset, `err_count` is 0, `err_flag` is 0 and `first_err_idx` is 0.
- R2: With no strike, a run of any length in either mode and with any inverter selection records no error. The source drives 0 on the first shift after `start` and alternates on every later shift.
- R3: `inv_sel` code 0 places no inverters on each link, code 1 places INV_UNIT inverters, and codes 2 and 3 place 2*INV_UNIT. When the inverters per link are odd, the expected tail value is inverted once for every link.
- R4: A comparison is made only in a cycle with `run` high, and only once N_STAGES shifts have happened since the last `start`. A corrupted bit that reaches the tail before that point is not counted.
- R5: In plain mode, a strike on copy 0 (`inj_copy` = 0) of stage j during shift m produces exactly one error, provided its arrival falls inside the run. A strike on copy 1 or 2, or with `inj_copy` = 3, produces none.
- R6: In hardened mode, a strike on any single copy of any stage during a run produces no error.
- R7: While `run` is low, the chain and the source hold. In hardened mode every copy is rewritten with its stage's voted value, so strikes on two different copies of one stage two cycles apart leave no error. A pause in the middle of a run causes no error.
- R8: `err_count` rises by one for each mismatch and saturates at 2^CNT_W-1. `err_flag` is set by the first mismatch and stays set until `start` or reset.
- R9: `first_err_idx` holds the number of comparisons made before the first mismatch since `start` (0 for the first compared cycle), and it does not change after that mismatch.
- R10: A `start` pulse clears `err_count`, `err_flag` and `first_err_idx`, and restarts both the source phase and the fill count. No shift takes place in the `start` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears results and restarts pattern and fill count |
| run | input | 1 | High: chain shifts; low: chain holds |
| harden | input | 1 | 1 selects majority-voted triple storage |
| inv_sel | input | 2 | Inverters per link: 0 none, 1 INV_UNIT, 2/3 twice INV_UNIT |
| inj_en | input | 1 | Flip one storage copy at this clock |
| inj_stage | input | clog2(N_STAGES) | Stage index hit by the strike |
| inj_copy | input | 2 | Copy hit (0..2); 3 hits none |
| err_count | output | CNT_W | Saturating mismatch count |
| err_flag | output | 1 | Sticky mismatch flag |
| first_err_idx | output | IDX_W | Comparison index of first mismatch |
| chain_q | output | 1 | Tail stage output |

## Verification
The hardest case to reach from the ports is a repair by voted feedback while the chain is paused. During a run the chain reloads every copy from the link, which hides any fault in the feedback path. The bench therefore pauses a filled chain and strikes copy 0 of one stage. Two cycles later it strikes copy 1 of the same stage, then resumes the run. Without feedback, two copies would now disagree with the voted value and the error would reach the tail. The exact error positions come from the strike timing: a strike on stage j during shift m shows up as comparison m-j.

// File: rtl/shift_upset_monitor.sv
module shift_upset_monitor #(
  parameter int N_STAGES = 64,
  parameter int INV_UNIT = 4,
  parameter int CNT_W    = 16,
  parameter int IDX_W    = 24,
  localparam int STG_W   = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             harden,
  input  logic [1:0]       inv_sel,
  input  logic             inj_en,
  input  logic [STG_W-1:0] inj_stage,
  input  logic [1:0]       inj_copy,
  output logic [CNT_W-1:0] err_count,
  output logic             err_flag,
  output logic [IDX_W-1:0] first_err_idx,
  output logic             chain_q
);
  localparam int FILL_W  = $clog2(N_STAGES + 1);
  localparam int MAX_INV = 2 * INV_UNIT;
  localparam logic N_ODD    = (N_STAGES % 2) == 1;
  localparam logic LINK_ODD = ((N_STAGES - 1) % 2) == 1;
  localparam logic UNIT_ODD = (INV_UNIT % 2) == 1;
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0]  IDX_MAX = {IDX_W{1'b1}};
  localparam logic [FILL_W-1:0] FULL    = FILL_W'(N_STAGES);

  logic [N_STAGES-1:0] q;
  logic [N_STAGES-1:0] d;
  logic                pat;
  logic [FILL_W-1:0]   fill;
  logic [IDX_W-1:0]    chk_cnt;

  wire shift   = run && !start;
  wire chk     = shift && (fill == FULL);
  wire exp_bit = pat ^ N_ODD ^ (LINK_ODD && UNIT_ODD && inv_sel == 2'd1);
  wire miss    = chk && (q[N_STAGES-1] != exp_bit);

  assign d[0]    = pat;
  assign chain_q = q[N_STAGES-1];

  for (genvar i = 0; i < N_STAGES - 1; i++) begin : g_link
    logic [MAX_INV:0] tap;
    assign tap[0] = q[i];
    for (genvar j = 0; j < MAX_INV; j++) begin : g_inv
      assign tap[j+1] = ~tap[j];
    end
    assign d[i+1] = (inv_sel == 2'd0) ? tap[0] :
                    (inv_sel == 2'd1) ? tap[INV_UNIT] : tap[MAX_INV];
  end

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    logic c0, c1, c2;
    wire hit = inj_en && (inj_stage == STG_W'(i));
    wire nxt = shift ? d[i] : q[i];
    assign q[i] = harden ? ((c0 & c1) | (c0 & c2) | (c1 & c2)) : c0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c0 <= 1'b0;
        c1 <= 1'b0;
        c2 <= 1'b0;
      end else begin
        c0 <= nxt ^ (hit && inj_copy == 2'd0);
        c1 <= nxt ^ (hit && inj_copy == 2'd1);
        c2 <= nxt ^ (hit && inj_copy == 2'd2);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat           <= 1'b0;
      fill          <= '0;
      chk_cnt       <= '0;
      err_count     <= '0;
      err_flag      <= 1'b0;
      first_err_idx <= '0;
    end else if (start) begin
      pat           <= 1'b0;
      fill          <= '0;
      chk_cnt       <= '0;
      err_count     <= '0;
      err_flag      <= 1'b0;
      first_err_idx <= '0;
    end else if (shift) begin
      pat <= ~pat;
      if (fill != FULL) fill <= fill + 1'b1;
      if (chk && chk_cnt != IDX_MAX) chk_cnt <= chk_cnt + 1'b1;
      if (miss) begin
        if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
        err_flag <= 1'b1;
        if (!err_flag) first_err_idx <= chk_cnt;
      end
    end
  end
endmodule

// File: rtl/shift_upset_monitor_chk.sv
module shift_upset_monitor_chk #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             run,
  input logic             harden,
  input logic             inj_en,
  input logic             chain_q,
  input logic [CNT_W-1:0] err_count,
  input logic             err_flag,
  input logic [IDX_W-1:0] first_err_idx
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (err_count == '0 && !err_flag && first_err_idx == '0));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CMAX && !start) |=> err_count == CMAX);

  p_step_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && err_count != CMAX) |=>
      (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !start) |=> err_flag);

  p_flag_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> err_count != '0);

  p_first_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !start) |=> $stable(first_err_idx));

  p_hold_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !start && !inj_en) |=> ($stable(chain_q) || !$stable(harden)));
endmodule

bind shift_upset_monitor shift_upset_monitor_chk #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run(run), .harden(harden),
  .inj_en(inj_en), .chain_q(chain_q), .err_count(err_count),
  .err_flag(err_flag), .first_err_idx(first_err_idx)
);

// File: tb/sim_shift_upset_monitor.sv
module sim_shift_upset_monitor;
  localparam int CLK_P = 10;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, run = 1'b0, harden = 1'b0, inj_en = 1'b0;
  logic [1:0] inv_sel = 2'd0, inj_copy = 2'd3;
  logic [5:0] stg0 = '0;
  logic [2:0] stg1 = 3'd7;
  logic [15:0] cnt0;
  logic [3:0]  cnt1;
  logic flag0, flag1, q0, q1;
  logic [23:0] idx0, idx1;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  shift_upset_monitor u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .harden(harden),
    .inv_sel(inv_sel), .inj_en(inj_en), .inj_stage(stg0), .inj_copy(inj_copy),
    .err_count(cnt0), .err_flag(flag0), .first_err_idx(idx0), .chain_q(q0));

  shift_upset_monitor #(.N_STAGES(NB), .INV_UNIT(3), .CNT_W(4), .IDX_W(24)) u1 (
    .clk(clk), .rst_n(rst_n), .start(start), .run(run), .harden(harden),
    .inv_sel(inv_sel), .inj_en(inj_en), .inj_stage(stg1), .inj_copy(inj_copy),
    .err_count(cnt1), .err_flag(flag1), .first_err_idx(idx1), .chain_q(q1));

  // harden, inv_sel, stage, copy, strike shift (-1 none), length, errors, first index
  localparam int VEC [15][8] = '{
    '{0, 0,  0, 3, -1, 100, 0,  0},
    '{0, 1,  0, 3, -1, 100, 0,  0},
    '{0, 2,  0, 3, -1, 100, 0,  0},
    '{0, 3,  0, 3, -1, 100, 0,  0},
    '{0, 0, 10, 0, 20, 100, 1, 10},
    '{0, 1, 63, 0, 70, 100, 1,  7},
    '{0, 2,  0, 0, 30, 100, 1, 30},
    '{0, 0,  5, 1, 20, 100, 0,  0},
    '{0, 1,  5, 2, 20, 100, 0,  0},
    '{1, 0, 10, 0, 20, 100, 0,  0},
    '{1, 2, 63, 2, 70, 100, 0,  0},
    '{1, 1, 30, 1, 50, 100, 0,  0},
    '{0, 0, 40, 0, 10, 100, 0,  0},
    '{1, 3,  0, 3, -1, 100, 0,  0},
    '{0, 0, 20, 3, 30, 100, 0,  0}
  };

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    start = 1'b1; run = 1'b0; inj_en = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_for(int len, int lo, int hi);
    run = 1'b1;
    for (int m = 0; m < len; m++) begin
      inj_en = (m >= lo && m <= hi);
      @(negedge clk);
    end
    run = 1'b0; inj_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n, logic strike);
    run = 1'b0;
    for (int k = 0; k < n; k++) begin
      inj_en = strike && (k == 0);
      @(negedge clk);
    end
    inj_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset count", cnt0, 0);
    check("R1 reset flag", flag0, 0);
    check("R1 reset index", idx0, 0);

    // R2 R3 R4 R5 R6 R9: table walk
    for (int r = 0; r < 15; r++) begin
      harden = VEC[r][0][0]; inv_sel = VEC[r][1][1:0];
      stg0 = VEC[r][2][5:0]; inj_copy = VEC[r][3][1:0]; stg1 = 3'd7;
      do_start();
      run_for(VEC[r][5], VEC[r][4], VEC[r][4]);
      check($sformatf("R5 R6 table row %0d count", r), cnt0, VEC[r][6]);
      check($sformatf("R8 table row %0d flag", r), flag0, (VEC[r][6] != 0) ? 1 : 0);
      check($sformatf("R9 table row %0d first index", r), idx0, VEC[r][7]);
    end

    // R7 pause mid-run
    harden = 1'b0; inv_sel = 2'd1; inj_copy = 2'd3;
    do_start(); run_for(70, -1, -1); idle(5, 1'b0); run_for(30, -1, -1);
    check("R7 pause causes no error", cnt0, 0);

    // R7 hold with voted feedback: two copies struck two cycles apart
    for (int h = 0; h < 2; h++) begin
      harden = h[0]; inv_sel = 2'd0; stg0 = 6'd20;
      do_start(); run_for(80, -1, -1);
      inj_copy = 2'd0; idle(2, 1'b1);
      inj_copy = 2'd1; idle(2, 1'b1);
      inj_copy = 2'd3;
      run_for(60, -1, -1);
      check(h == 1 ? "R7 hardened hold repairs copies" : "R7 plain hold keeps upset",
            cnt0, h == 1 ? 0 : 1);
    end

    // R3 odd inverter units on the small chain
    harden = 1'b0; inj_copy = 2'd3; stg1 = 3'd7;
    for (int s = 0; s < 3; s++) begin
      inv_sel = s[1:0];
      do_start(); run_for(40, -1, -1);
      check($sformatf("R3 odd unit sel %0d", s), cnt1, 0);
    end

    // R8 saturation and R9 index on the small chain
    inv_sel = 2'd1; inj_copy = 2'd0; stg1 = 3'd7;
    do_start(); run_for(40, 10, 29);
    check("R8 saturated count", cnt1, 15);
    check("R8 sticky flag", flag1, 1);
    check("R9 first index small chain", idx1, 3);

    // R4 strikes before the window opens are not counted
    do_start(); run_for(9, 0, 6);
    check("R4 early strikes ignored", cnt1, 0);

    // R10 start clears
    do_start(); run_for(40, 10, 29);
    do_start();
    check("R10 count cleared", cnt1, 0);
    check("R10 flag cleared", flag1, 0);
    check("R10 index cleared", idx1, 0);
    inj_copy = 2'd3;
    run_for(30, -1, -1);
    check("R10 restart phase clean", cnt1, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule